// File: doc/BRIEF.md
# Color TV Standard Search Controller

This block decides which analog color television standard an incoming video signal uses. Software writes a control word that holds a mask of the standards it allows and a global run bit. The block watches the field rate class that a separate timing unit measures (50 Hz, 60 Hz or invalid). It then offers enabled standards of that rate class one at a time on a candidate output. For each candidate, an external color decoder returns one verdict: whether any color carrier was seen, which standard that color looked like, and whether it locked on the candidate.

The search stops on the first lock or when no candidates remain. The outcome sits in a six-bit status word that software reads through the same register port. A sticky change flag records every switch of the locked standard, and software clears it through a self-clearing bit in the control word. Any change of the field rate class, the mask or the run bit starts a fresh search from the lowest eligible standard.

Top module: `asr_ctrl`

## Requirements
- R1: After reset the control word and the status word read 0, and the candidate index and subcarrier code are 0.
- R2: Address 0 is the control word. Bits 6:0 are the standard mask, bit 12 is the run bit, and bit 11 is the change-flag clear. Bits 10:7 always read 0, and bit 11 reads 0 once its one-cycle pulse has passed. Address 1 returns the status word in bits 5:0.
- R3: When the field rate input is 2'b00 or 2'b11 (invalid), no search starts and the status is 6'h01.
- R4: When no enabled standard has the measured rate class, no search starts and status bit 1 is set (status 6'h02).
- R5: Mask index i selects a standard: 0 PAL B/G/H/I, 1 NTSC M, 2 SECAM, 3 NTSC 4.43, 4 PAL M, 5 PAL N, 6 PAL 60. Indices 1, 3, 4 and 6 are 60 Hz (field rate 2'b10) and the rest are 50 Hz (2'b01). Candidates are tried in ascending index order, skipping masked and wrong-rate ones. Status bit 2 is set while a search runs.
- R6: A verdict with lock ends the search, clears status bits 4:0 and keeps the locked index on the candidate output.
- R7: When the list runs out after at least one trial saw color, status bit 3 is set. Bit 1 is also set (6'h0A) if the standard reported by the last colored trial is masked off.
- R8: When the list runs out and no trial saw color, the status is bit 4 alone (6'h10).
- R9: Status bit 5 sets when a lock lands on a standard that differs from the previous lock (the first lock after reset counts). It stays set through further searches.
- R10: Writing 1 to control bit 11 clears status bit 5, and the write with an unchanged mask and run bit does not restart the search.
- R11: Clearing the run bit stops the search, clears status bits 4:0 and leaves the candidate unchanged. Verdicts are then ignored.
- R12: A change of the field rate input while running restarts the search from the lowest eligible index.
- R13: The subcarrier code output maps the candidate to 0 = 4.433618 MHz (indices 0, 3, 6), 1 = 3.579545 MHz (1), 2 = 4.286 MHz (2), 3 = 3.575611 MHz (4) and 4 = 3.582056 MHz (5).
- R14: Verdicts that arrive when no search is in progress change neither status nor candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = status word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| field_rate | input | 2 | 01 = 50 Hz, 10 = 60 Hz, other = invalid |
| trial_done | input | 1 | One-cycle verdict strobe for the current candidate |
| trial_color | input | 1 | Verdict: a color carrier was seen |
| trial_lock | input | 1 | Verdict: decoder locked on the candidate |
| trial_seen_std | input | 3 | Verdict: index of the standard the seen color resembles |
| cand_std | output | 3 | Current candidate standard index |
| cand_sc | output | 3 | Subcarrier code of the candidate |

## Verification
The assertions assume that the decoder raises at most one verdict per candidate. They also assume that a verdict with lock also has color, and that the field rate input changes no faster than once every few cycles. They further assume that software never writes in two back-to-back cycles. The stimulus drives every verdict as a single-cycle strobe. It then waits at least three cycles before the next write, rate change or verdict, so each restart settles before the next event.

// File: rtl/asr_pkg.sv
package asr_pkg;

    localparam int NSTD    = 7;
    localparam int IW      = 3;
    localparam int DW      = 16;
    localparam int CLR_BIT = 11;
    localparam int RUN_BIT = 12;
    localparam int SW      = 6;

    // one bit per standard index: 1 = 60 Hz family
    localparam logic [NSTD-1:0] RATE60_MAP = 7'b1011010;

    localparam logic [1:0] RATE_50 = 2'b01;
    localparam logic [1:0] RATE_60 = 2'b10;

    localparam int S_VWIN  = 0;
    localparam int S_DIS   = 1;
    localparam int S_BUSY  = 2;
    localparam int S_FAIL  = 3;
    localparam int S_NOCOL = 4;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_START,
        ST_SEARCH,
        ST_HOLD
    } asr_state_e;

    function automatic logic [2:0] sc_code(input logic [IW-1:0] idx);
        case (idx)
            3'd1:    sc_code = 3'd1;
            3'd2:    sc_code = 3'd2;
            3'd4:    sc_code = 3'd3;
            3'd5:    sc_code = 3'd4;
            default: sc_code = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/asr_pick.sv
module asr_pick
    import asr_pkg::*;
#(
    parameter int N = NSTD,
    parameter int W = IW
) (
    input  logic [N-1:0] mask,
    input  logic         want60,
    input  logic [W:0]   from,
    output logic         hit,
    output logic [W-1:0] idx
);

    logic [N-1:0] elig;

    for (genvar i = 0; i < N; i++) begin : g_elig
        assign elig[i] = mask[i] && (RATE60_MAP[i] == want60) && ((W+1)'(i) >= from);
    end

    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit = 1'b1;
                idx = W'(i);
            end
        end
    end

endmodule

// File: rtl/asr_regs.sv
module asr_regs
    import asr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic            addr,
    input  logic [DW-1:0]   wdata,
    input  logic [SW-1:0]   status,
    output logic [DW-1:0]   rdata,
    output logic [NSTD-1:0] mask,
    output logic            run,
    output logic            clr,
    output logic            chg
);

    typedef struct packed {
        logic [NSTD-1:0] mask;
        logic            run;
        logic            clr;
        logic            chg;
    } regs_t;

    regs_t q, d;
    logic  unused_wbits;

    assign unused_wbits = ^{wdata[DW-1:RUN_BIT+1], wdata[CLR_BIT-1:NSTD]};

    always_comb begin
        d     = q;
        d.clr = 1'b0;
        d.chg = 1'b0;
        if (wr && !addr) begin
            d.mask = wdata[NSTD-1:0];
            d.run  = wdata[RUN_BIT];
            d.clr  = wdata[CLR_BIT];
            d.chg  = (wdata[NSTD-1:0] != q.mask) || (wdata[RUN_BIT] != q.run);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        if (!addr) begin
            rdata[NSTD-1:0] = q.mask;
            rdata[CLR_BIT]  = q.clr;
            rdata[RUN_BIT]  = q.run;
        end else begin
            rdata[SW-1:0] = status;
        end
    end

    assign mask = q.mask;
    assign run  = q.run;
    assign clr  = q.clr;
    assign chg  = q.chg;

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr |-> (rdata[CLR_BIT-1:NSTD] == '0));

endmodule

// File: rtl/asr_core.sv
module asr_core
    import asr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [NSTD-1:0] mask,
    input  logic            chg,
    input  logic            clr,
    input  logic [1:0]      field_rate,
    input  logic            trial_done,
    input  logic            trial_color,
    input  logic            trial_lock,
    input  logic [IW-1:0]   trial_seen_std,
    output logic [IW-1:0]   cand,
    output logic [SW-1:0]   status
);

    localparam int NPAD = 1 << IW;

    typedef struct packed {
        asr_state_e     state;
        logic [IW-1:0]  cand;
        logic [4:0]     stat;
        logic           sw;
        logic [1:0]     rate;
        logic           seen;
        logic [IW-1:0]  seen_std;
        logic [IW-1:0]  locked;
        logic           locked_any;
    } core_t;

    core_t q, d;

    logic [NPAD-1:0] mask_x;
    logic [NPAD-1:0] map_x;
    logic [IW:0]     pk_from;
    logic            pk_hit;
    logic [IW-1:0]   pk_idx;
    logic            want60;
    logic            rate_ok;

    assign mask_x  = NPAD'(mask);
    assign map_x   = NPAD'(RATE60_MAP);
    assign want60  = (q.rate == RATE_60);
    assign rate_ok = (q.rate == RATE_50) || (q.rate == RATE_60);
    assign pk_from = (q.state == ST_SEARCH) ? ({1'b0, q.cand} + 1'b1) : '0;

    asr_pick #(.N(NSTD), .W(IW)) u_pick (
        .mask   (mask),
        .want60 (want60),
        .from   (pk_from),
        .hit    (pk_hit),
        .idx    (pk_idx)
    );

    always_comb begin
        logic          sw_set;
        logic          seen_n;
        logic [IW-1:0] std_n;

        d      = q;
        d.rate = field_rate;
        sw_set = 1'b0;
        seen_n = q.seen;
        std_n  = q.seen_std;

        if (!run) begin
            d.state = ST_OFF;
            d.stat  = '0;
        end else if (chg || (field_rate != q.rate) || (q.state == ST_OFF)) begin
            d.state = ST_START;
        end else begin
            case (q.state)
                ST_START: begin
                    d.seen = 1'b0;
                    d.stat = '0;
                    if (!rate_ok) begin
                        d.stat[S_VWIN] = 1'b1;
                        d.state        = ST_HOLD;
                    end else if (!pk_hit) begin
                        d.stat[S_DIS] = 1'b1;
                        d.state       = ST_HOLD;
                    end else begin
                        d.cand         = pk_idx;
                        d.stat[S_BUSY] = 1'b1;
                        d.state        = ST_SEARCH;
                    end
                end
                ST_SEARCH: begin
                    if (trial_done) begin
                        if (trial_lock) begin
                            d.stat  = '0;
                            d.state = ST_HOLD;
                            sw_set  = !q.locked_any || (q.locked != q.cand);
                            d.locked     = q.cand;
                            d.locked_any = 1'b1;
                        end else begin
                            seen_n     = q.seen || trial_color;
                            std_n      = trial_color ? trial_seen_std : q.seen_std;
                            d.seen     = seen_n;
                            d.seen_std = std_n;
                            if (pk_hit) begin
                                d.cand = pk_idx;
                            end else begin
                                d.state = ST_HOLD;
                                d.stat  = '0;
                                if (seen_n) begin
                                    d.stat[S_FAIL] = 1'b1;
                                    d.stat[S_DIS]  = !mask_x[std_n];
                                end else begin
                                    d.stat[S_NOCOL] = 1'b1;
                                end
                            end
                        end
                    end
                end
                default: ;
            endcase
        end

        if (sw_set)   d.sw = 1'b1;
        else if (clr) d.sw = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cand   = q.cand;
    assign status = {q.sw, q.stat};

    p_cand_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_SEARCH && !chg) |->
            (mask_x[cand] && (map_x[cand] == (q.rate == RATE_60))));

    p_code_shape_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(status[4:0]) || (status[4:0] == 5'b01010));

    p_sw_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(status[5]) && !$past(clr)) |-> status[5]);

    p_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> ($stable(cand) && status[4:0] == '0));

endmodule

// File: rtl/asr_ctrl.sv
module asr_ctrl
    import asr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_addr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic [1:0]    field_rate,
    input  logic          trial_done,
    input  logic          trial_color,
    input  logic          trial_lock,
    input  logic [2:0]    trial_seen_std,
    output logic [2:0]    cand_std,
    output logic [2:0]    cand_sc
);

    logic [NSTD-1:0] mask;
    logic            run;
    logic            clr;
    logic            chg;
    logic [SW-1:0]   status;

    asr_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .status (status),
        .rdata  (reg_rdata),
        .mask   (mask),
        .run    (run),
        .clr    (clr),
        .chg    (chg)
    );

    asr_core u_core (
        .clk            (clk),
        .rst_n          (rst_n),
        .run            (run),
        .mask           (mask),
        .chg            (chg),
        .clr            (clr),
        .field_rate     (field_rate),
        .trial_done     (trial_done),
        .trial_color    (trial_color),
        .trial_lock     (trial_lock),
        .trial_seen_std (trial_seen_std),
        .cand           (cand_std),
        .status         (status)
    );

    assign cand_sc = sc_code(cand_std);

endmodule

// File: tb/test_asr_ctrl.sv
module test_asr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [1:0]  field_rate = 2'b00;
    logic        trial_done = 1'b0;
    logic        trial_color = 1'b0;
    logic        trial_lock = 1'b0;
    logic [2:0]  trial_seen_std = '0;
    logic [2:0]  cand_std;
    logic [2:0]  cand_sc;

    always #5 clk = ~clk;

    asr_ctrl i_asr_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .field_rate(field_rate),
        .trial_done(trial_done), .trial_color(trial_color), .trial_lock(trial_lock),
        .trial_seen_std(trial_seen_std), .cand_std(cand_std), .cand_sc(cand_sc)
    );

    typedef enum int {K_RD, K_CAND, K_SC} kind_e;
    typedef struct {
        kind_e       kind;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q_exp[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    // monitor: compares queued expectations away from the rising edge
    always @(negedge clk) begin
        while (q_exp.size() > 0) begin
            item_t       it;
            logic [15:0] act;
            it = q_exp.pop_front();
            case (it.kind)
                K_RD:    act = reg_rdata;
                K_CAND:  act = {13'b0, cand_std};
                default: act = {13'b0, cand_sc};
            endcase
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_item(input kind_e k, input logic addr, input logic [15:0] e, input string tag);
        item_t it;
        reg_addr = addr;
        it.kind = k;
        it.exp  = e;
        it.tag  = tag;
        q_exp.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic exp_status(input logic [15:0] e, input string tag);
        expect_item(K_RD, 1'b1, e, tag);
    endtask

    task automatic exp_cand(input logic [2:0] c, input logic [2:0] sc, input string tag);
        expect_item(K_CAND, 1'b0, {13'b0, c}, tag);
        expect_item(K_SC, 1'b0, {13'b0, sc}, tag);
    endtask

    task automatic wr_ctrl(input logic [15:0] v);
        reg_wr    = 1'b1;
        reg_addr  = 1'b0;
        reg_wdata = v;
        tick(1);
        reg_wr = 1'b0;
        tick(3);
    endtask

    task automatic set_rate(input logic [1:0] r);
        field_rate = r;
        tick(3);
    endtask

    task automatic verdict(input logic col, input logic lk, input logic [2:0] s);
        trial_done     = 1'b1;
        trial_color    = col;
        trial_lock     = lk;
        trial_seen_std = s;
        tick(1);
        trial_done = 1'b0;
        trial_color = 1'b0;
        trial_lock = 1'b0;
        tick(2);
    endtask

    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        field_rate = 2'b11;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        exp_status(16'h0000, "R1 status");
        expect_item(K_RD, 1'b0, 16'h0000, "R1 ctrl");
        exp_cand(3'd0, 3'd0, "R1 cand");

        // R2 readback, R3 invalid rate
        wr_ctrl(16'h17FF);
        expect_item(K_RD, 1'b0, 16'h107F, "R2 ctrl readback");
        exp_status(16'h0001, "R3 invalid rate");

        // R5 60 Hz order with no color, R13 codes, R8 no color
        set_rate(2'b10);
        exp_status(16'h0004, "R5 busy");
        exp_cand(3'd1, 3'd1, "R5 R13 first 60Hz");
        verdict(1'b0, 1'b0, 3'd0);
        exp_cand(3'd3, 3'd0, "R5 R13 second");
        verdict(1'b0, 1'b0, 3'd0);
        exp_cand(3'd4, 3'd3, "R5 R13 third");
        verdict(1'b0, 1'b0, 3'd0);
        exp_cand(3'd6, 3'd0, "R5 R13 fourth");
        verdict(1'b0, 1'b0, 3'd0);
        exp_status(16'h0010, "R8 no color");

        // R12 restart, R6 lock, R9 first lock switch
        set_rate(2'b01);
        exp_status(16'h0004, "R12 restart busy");
        exp_cand(3'd0, 3'd0, "R12 lowest 50Hz");
        verdict(1'b1, 1'b1, 3'd0);
        exp_status(16'h0020, "R6 R9 lock sets switch");
        exp_cand(3'd0, 3'd0, "R6 held");
        // R14 verdict after lock ignored
        verdict(1'b0, 1'b0, 3'd0);
        exp_status(16'h0020, "R14 status");
        exp_cand(3'd0, 3'd0, "R14 cand");

        // R10 clear switch without restart
        wr_ctrl(16'h187F);
        exp_status(16'h0000, "R10 cleared");
        expect_item(K_RD, 1'b0, 16'h107F, "R10 R2 bit11 self-clear");
        exp_cand(3'd0, 3'd0, "R10 no restart");

        // R12 rate change, R9 switch to a different standard
        set_rate(2'b10);
        exp_cand(3'd1, 3'd1, "R12 restart at 1");
        verdict(1'b1, 1'b0, 3'd0);
        exp_cand(3'd3, 3'd0, "R5 advance");
        verdict(1'b1, 1'b1, 3'd3);
        exp_status(16'h0020, "R9 switch");
        exp_cand(3'd3, 3'd0, "R6 lock ntsc443");
        set_rate(2'b01);
        verdict(1'b1, 1'b1, 3'd0);
        exp_status(16'h0020, "R9 sticky");
        wr_ctrl(16'h187F);
        exp_status(16'h0000, "R10 second clear");

        // R7 failure with enabled color
        wr_ctrl(16'h1005);
        exp_cand(3'd0, 3'd0, "R5 mask 05 first");
        verdict(1'b1, 1'b0, 3'd2);
        exp_cand(3'd2, 3'd2, "R5 R13 secam");
        verdict(1'b1, 1'b0, 3'd2);
        exp_status(16'h0008, "R7 failed");

        // R7 failure with disabled color
        wr_ctrl(16'h1004);
        exp_status(16'h0004, "R7 busy");
        verdict(1'b1, 1'b0, 3'd0);
        exp_status(16'h000A, "R7 disabled color");

        // R4 no matching enabled standard
        field_rate = 2'b10;
        wr_ctrl(16'h1005);
        exp_status(16'h0002, "R4 no match");

        // R11 disable mid search
        field_rate = 2'b01;
        wr_ctrl(16'h107F);
        exp_status(16'h0004, "R11 pre busy");
        verdict(1'b0, 1'b0, 3'd0);
        exp_cand(3'd2, 3'd2, "R11 advanced");
        wr_ctrl(16'h007F);
        exp_status(16'h0000, "R11 stopped");
        exp_cand(3'd2, 3'd2, "R11 cand kept");
        verdict(1'b1, 1'b1, 3'd2);
        exp_status(16'h0000, "R11 R14 verdict ignored");
        exp_cand(3'd2, 3'd2, "R11 cand after verdict");
        expect_item(K_RD, 1'b0, 16'h007F, "R2 run cleared");

        tick(2);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule